// File: doc/BRIEF.md
# Funnel-Shift Bit-Field Unit

This block is a purely combinational 32-bit field engine. It takes two operand words, `left_i` and `right_i`, and a 16-bit control word. The pair is funnel-shifted so that `left_i` moves up and the vacated low positions fill from the top of `right_i`. A low-order mask then selects part of the shifted word. The mask can have a hole cut at its bottom, which lets the same datapath serve two uses. In extract mode, a field lands in a background of zeros. In insert mode, a shifted field is placed into `right_i`, and the bits of `right_i` outside the field are kept.

The control word holds three things: a shift count, a mask width and an insert flag. The result depends only on the present inputs. It appears in the same cycle as the inputs, with no register on the way. Data is not streamed, so there is no handshake. The caller presents a word pair and a control word and reads the result.

Top module: `fsx_field_unit`

## Requirements
- R1: The control word layout is: bits [5:0] are the shift count, bits [11:6] are the mask width, and bit 12 is the insert flag (1 selects insert). Bits [15:13] have no effect on the result.
- R2: A shift count or mask width above 32 behaves exactly like 32.
- R3: With a shift count of 0, the shifted word equals `left_i`.
- R4: With a shift count of 32, the shifted word equals `right_i`.
- R5: With a shift count s from 1 to 31, the shifted word is `left_i` moved up by s positions. Its low s bits are the top s bits of `right_i`.
- R6: The primary mask has ones in exactly the low m positions, where m is the mask width. A width of 0 gives all zeros and a width of 32 gives all ones.
- R7: In extract mode, the result is the shifted word ANDed with the primary mask, so every bit at or above position m is 0.
- R8: In insert mode, the effective mask is the primary mask XOR a mask of ones in the low s positions. Every result bit where the effective mask is 0 equals the same bit of `right_i`.
- R9: In insert mode, every result bit where the effective mask is 1 equals the same bit of the shifted word.
- R10: The result responds to an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| left_i | input | 32 | Upper operand of the funnel |
| right_i | input | 32 | Lower operand of the funnel; also the background in insert mode |
| ctrl_i | input | 16 | Control word: shift count, mask width, insert flag |
| result_o | output | 32 | Masked and merged result |

## Verification
The assertions assume that all inputs are known (not X or Z) whenever they are evaluated, and they skip any evaluation in which an input is unknown. They do not assume that the count fields are 32 or less: values up to 63 are legal, and the decoder clamps them. The bench drives fully defined operands from reset onward. Its sweep deliberately includes raw counts above 32 and set high control bits, so the clamp and the ignored bits are exercised within the same legal input space.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  parameter int FSX_WIDTH = 32;
  parameter int FSX_CTRL_W = 16;
  localparam int FSX_CNT_W = $clog2(FSX_WIDTH + 1);

  typedef struct packed {
    logic                 insert;
    logic [FSX_CNT_W-1:0] mask_cnt;
    logic [FSX_CNT_W-1:0] shift_cnt;
  } fsx_ctrl_t;
endpackage

// File: rtl/fsx_ctrl_decode.sv
module fsx_ctrl_decode
  import fsx_pkg::*;
#(
  parameter int WIDTH  = FSX_WIDTH,
  parameter int CTRL_W = FSX_CTRL_W
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output fsx_ctrl_t         dec_o
);
  localparam int CW = FSX_CNT_W;
  localparam logic [CW-1:0] CMAX = CW'(WIDTH);

  logic [CW-1:0] raw_shift, raw_mask;
  logic          unused_hi;

  assign raw_shift = ctrl_i[CW-1:0];
  assign raw_mask  = ctrl_i[2*CW-1:CW];
  assign unused_hi = ^ctrl_i[CTRL_W-1:2*CW+1];

  always_comb begin
    dec_o.insert    = ctrl_i[2*CW];
    dec_o.shift_cnt = (raw_shift > CMAX) ? CMAX : raw_shift;
    dec_o.mask_cnt  = (raw_mask  > CMAX) ? CMAX : raw_mask;
  end

  always_comb begin
    if (!$isunknown(ctrl_i))
      AST_COUNT_CLAMPED: assert (dec_o.shift_cnt <= CMAX && dec_o.mask_cnt <= CMAX); // R2
  end
endmodule

// File: rtl/fsx_funnel.sv
module fsx_funnel
  import fsx_pkg::*;
#(
  parameter int WIDTH = FSX_WIDTH
) (
  input  logic [WIDTH-1:0]     hi_i,
  input  logic [WIDTH-1:0]     lo_i,
  input  logic [FSX_CNT_W-1:0] amt_i,
  output logic [WIDTH-1:0]     out_o
);
  localparam int DW = 2 * WIDTH;

  logic [DW-1:0]    joined;
  logic [WIDTH-1:0] unused_lo;

  assign joined    = {hi_i, lo_i} << amt_i;
  assign out_o     = joined[DW-1:WIDTH];
  assign unused_lo = joined[WIDTH-1:0];

  always_comb begin
    if (!$isunknown({hi_i, lo_i, amt_i})) begin
      if (amt_i == '0)
        AST_SHIFT_ZERO_PASS: assert (out_o == hi_i); // R3
      if (amt_i == FSX_CNT_W'(WIDTH))
        AST_SHIFT_FULL_PASS: assert (out_o == lo_i); // R4
    end
  end
endmodule

// File: rtl/fsx_mask_gen.sv
module fsx_mask_gen
  import fsx_pkg::*;
#(
  parameter int WIDTH = FSX_WIDTH
) (
  input  logic [FSX_CNT_W-1:0] cnt_i,
  output logic [WIDTH-1:0]     mask_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mask_o[i] = (cnt_i > FSX_CNT_W'(i));
  end

  always_comb begin
    if (!$isunknown(cnt_i))
      AST_MASK_POPCOUNT: assert ($countones(mask_o) == int'(cnt_i)); // R6
  end
endmodule

// File: rtl/fsx_field_unit.sv
module fsx_field_unit
  import fsx_pkg::*;
#(
  parameter int WIDTH  = FSX_WIDTH,
  parameter int CTRL_W = FSX_CTRL_W
) (
  input  logic [WIDTH-1:0]  left_i,
  input  logic [WIDTH-1:0]  right_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o
);
  fsx_ctrl_t        dec;
  logic [WIDTH-1:0] shifted, prim_mask, hole_mask, eff_mask, backdrop;

  fsx_ctrl_decode #(.WIDTH(WIDTH), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_i (ctrl_i),
    .dec_o  (dec)
  );

  fsx_funnel #(.WIDTH(WIDTH)) u_funnel (
    .hi_i  (left_i),
    .lo_i  (right_i),
    .amt_i (dec.shift_cnt),
    .out_o (shifted)
  );

  fsx_mask_gen #(.WIDTH(WIDTH)) u_prim (
    .cnt_i  (dec.mask_cnt),
    .mask_o (prim_mask)
  );

  fsx_mask_gen #(.WIDTH(WIDTH)) u_hole (
    .cnt_i  (dec.shift_cnt),
    .mask_o (hole_mask)
  );

  assign eff_mask = dec.insert ? (prim_mask ^ hole_mask) : prim_mask;
  assign backdrop = dec.insert ? right_i : '0;
  assign result_o = (shifted & eff_mask) | (backdrop & ~eff_mask);

  always_comb begin
    if (!$isunknown({left_i, right_i, ctrl_i})) begin
      if (!dec.insert)
        AST_EXTRACT_ZERO_ABOVE: assert ((result_o & ~prim_mask) == '0); // R7
      if (dec.insert)
        AST_INSERT_KEEPS_RIGHT: assert ((result_o & ~eff_mask) == (right_i & ~eff_mask)); // R8
      if (dec.insert)
        AST_INSERT_FIELD_SHIFTED: assert ((result_o & eff_mask) == (shifted & eff_mask)); // R9
    end
  end
endmodule

// File: tb/fsx_field_unit_tb.sv
module fsx_field_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] left_i, right_i, result_o;
  logic [15:0] ctrl_i;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fsx_field_unit u_dut (
    .left_i   (left_i),
    .right_i  (right_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o)
  );

  function automatic logic [31:0] low_ones(int n);
    logic [63:0] t;
    t = (64'd1 << n) - 64'd1;
    return t[31:0];
  endfunction

  function automatic logic [31:0] model(logic [31:0] l, logic [31:0] r, int s, int m, bit ins);
    logic [31:0] sh, em, bg;
    if (s > 32) s = 32;
    if (m > 32) m = 32;
    if (s == 0) sh = l;
    else if (s == 32) sh = r;
    else sh = (l << s) | (r >> (32 - s));
    em = ins ? (low_ones(m) ^ low_ones(s)) : low_ones(m);
    bg = ins ? r : 32'h0;
    return (sh & em) | (bg & ~em);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(string req, logic [31:0] l, logic [31:0] r, int s, int m, bit ins, logic [2:0] hi);
    @(negedge clk);
    left_i  = l;
    right_i = r;
    ctrl_i  = {hi, ins, 6'(m), 6'(s)};
    #1;
    check(req, result_o, model(l, r, s, m, ins)); // R10: no clock edge in between
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    left_i = '0; right_i = '0; ctrl_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset state", result_o, 32'h0);
    rst_n = 1'b1;

    // R3 / R4 / R5 directed points
    run("R3", 32'hDEADBEEF, 32'h12345678, 0, 32, 1'b0, 3'b0);
    run("R4", 32'hDEADBEEF, 32'h12345678, 32, 32, 1'b0, 3'b0);
    run("R5", 32'h00000001, 32'h80000000, 1, 32, 1'b0, 3'b0);
    check("R5", result_o, 32'h00000003);
    run("R6", 32'hFFFFFFFF, 32'h0, 0, 0, 1'b0, 3'b0);
    check("R6", result_o, 32'h0);
    run("R6", 32'hFFFFFFFF, 32'h0, 0, 5, 1'b0, 3'b0);
    check("R6", result_o, 32'h0000001F);
    run("R8", 32'h000000FF, 32'hAAAAAAAA, 8, 16, 1'b1, 3'b0);
    check("R8", result_o, 32'hAAAAFFAA);

    // Full sweep of shift x mask in both modes, two operand patterns each
    for (int ins = 0; ins < 2; ins++) begin
      for (int s = 0; s <= 32; s++) begin
        for (int m = 0; m <= 32; m++) begin
          run(ins ? "R9" : "R7", $urandom, $urandom, s, m, ins[0], 3'b0);
          run(ins ? "R8" : "R5", 32'hF0F0A5C3, 32'h0FF15A3C, s, m, ins[0], 3'b0);
        end
      end
    end

    // R1: high control bits are ignored; R2: counts above 32 clamp
    for (int k = 0; k < 64; k++) begin
      int s = int'($urandom_range(0, 63));
      int m = int'($urandom_range(0, 63));
      logic [31:0] l = $urandom, r = $urandom;
      bit ins = k[0];
      run("R1", l, r, s, m, ins, 3'(k + 1));
      run("R2", l, r, s, m, ins, 3'b0);
    end
    run("R2", 32'h89ABCDEF, 32'h13579BDF, 63, 40, 1'b1, 3'b111);
    check("R2", result_o, 32'h13579BDF);
    run("R2", 32'h89ABCDEF, 32'h13579BDF, 45, 63, 1'b0, 3'b0);
    check("R2", result_o, 32'h13579BDF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule